// File: doc/BRIEF.md
# Clock Generator Watchdog with Recovery Lock

This block guards a clock generator while software retunes it. Once armed, it starts a countdown when a frequency change is accepted. If software does not disarm it before the countdown runs out, the block does four things:

- it sets a sticky timeout status bit;
- it locks the generator onto a recovery frequency;
- it reports which recovery source applies;
- it can pull the system reset line low for a fixed number of cycles.

While the lock holds, later software frequency changes are refused. The lock is released only by disarming the watchdog.

The countdown is a 5-bit unit count. The unit is chosen between a short base and a long base (nominally 150 ms and 2.5 s). Each base is given by a cycle-count parameter, so a simulation run stays short. The reset output is open-drain: a drive enable and an active-low level. A separate option uses the same reset output to request a reset after every accepted frequency change.

Top module: `freq_watchdog`

## Requirements
- R1: After rst_ni is released, timeout_status_o=0, lock_o=0, chg_ok_o=0, freq_src_o=2'b00, rst_n_o=1 and rst_oe_o=0.
- R2: With wd_en_i=1, counting starts only on an accepted freq_change_i. Expiry happens exactly units×T cycles after the accepting edge, where units is timeout_code_i and T is SHORT_TICKS when long_unit_i=0 and LONG_TICKS when long_unit_i=1.
- R3: A timeout_code_i of 0 counts 32 units.
- R4: Driving wd_en_i to 0 stops the count and discards it, so no expiry follows unless a new change is accepted.
- R5: An accepted change while the count runs restarts it from the full timeout.
- R6: timeout_status_o is set on expiry. It stays set until a cycle with status_wr_i=1 and status_wdata_i=1; a write with status_wdata_i=0 leaves it set.
- R7: Expiry sets lock_o. While locked, freq_src_o is 2'b01 (strap recovery) if rcv_src_i was 0 at expiry and 2'b10 (programmed recovery) if it was 1. Unlocked, freq_src_o is 2'b00.
- R8: While lock_o=1, freq_change_i is refused: no chg_ok_o pulse, no restart and no reset pulse.
- R9: A cycle with wd_en_i=0 clears lock_o at the next edge.
- R10: On expiry with rst_on_wd_i=1, rst_oe_o goes high and rst_n_o goes low from that edge for RST_LEN cycles. With rst_on_wd_i=0 no pulse is produced.
- R11: With rst_on_fchg_i=1, an accepted change starts the same reset pulse whether or not the watchdog is armed.
- R12: chg_ok_o is high for the one cycle after each edge that accepts a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_en_i | input | 1 | Watchdog arm; 0 stops, reloads and unlocks |
| timeout_code_i | input | 5 | Timeout in units, 0 means 32 |
| long_unit_i | input | 1 | Unit select: 0 short, 1 long |
| rst_on_wd_i | input | 1 | Reset pulse on expiry |
| rst_on_fchg_i | input | 1 | Reset pulse on accepted frequency change |
| rcv_src_i | input | 1 | Recovery source: 0 strap, 1 programmed |
| freq_change_i | input | 1 | Software frequency change request |
| status_wr_i | input | 1 | Status write strobe |
| status_wdata_i | input | 1 | Status write data, 1 clears |
| timeout_status_o | output | 1 | Sticky timeout status |
| lock_o | output | 1 | Recovery lock active |
| freq_src_o | output | 2 | 00 normal, 01 strap recovery, 10 programmed recovery |
| chg_ok_o | output | 1 | Frequency change accepted pulse |
| rst_n_o | output | 1 | Reset level, active low |
| rst_oe_o | output | 1 | Open-drain drive enable for the reset |

## Verification
The hardest situation to reach is a second change arriving mid-count. The bench issues a change, waits part of the window and issues another. It then expects the status edge at a full timeout after the second change, not the first; a count that is not restarted expires early, and the scoreboard sees that event at the wrong cycle. The refusal under lock is reached by letting a real expiry happen first. The bench then pulses a change with the frequency-change reset option on, and any acknowledge or reset edge the monitor sees is an unexpected item.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_NORMAL = 2'b00,
    SRC_STRAP  = 2'b01,
    SRC_PROG   = 2'b10
  } src_e;
endpackage

// File: rtl/fwd_tick.sv
module fwd_tick #(
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic long_i,
  output logic tick_o
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = long_i ? LIM_L : LIM_S;
  assign tick_o = run_i && !restart_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fwd_count.sv
module fwd_count #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              expire_o
);
  localparam int UW = CODE_W + 1;
  localparam logic [UW-1:0] FULL = UW'(1) << CODE_W;

  logic [UW-1:0] units_q;
  logic [UW-1:0] load;

  // code 0 stands for the full 2**CODE_W units
  assign load     = (code_i == '0) ? FULL : {1'b0, code_i};
  assign expire_o = en_i && run_o && !start_i && tick_i && (units_q == UW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      units_q <= FULL;
    end else if (!en_i) begin
      run_o   <= 1'b0;
      units_q <= load;
    end else if (start_i) begin
      run_o   <= 1'b1;
      units_q <= load;
    end else if (expire_o) begin
      run_o   <= 1'b0;
    end else if (tick_i) begin
      units_q <= units_q - UW'(1);
    end
  end
endmodule

// File: rtl/fwd_pulse.sv
module fwd_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);

  logic [PW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (trig_i)   cnt_q <= LEN_V;
    else if (active_o) cnt_q <= cnt_q - PW'(1);
  end
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog #(
  parameter int CODE_W      = 5,
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 32,
  parameter int RST_LEN     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_en_i,
  input  logic [CODE_W-1:0] timeout_code_i,
  input  logic              long_unit_i,
  input  logic              rst_on_wd_i,
  input  logic              rst_on_fchg_i,
  input  logic              rcv_src_i,
  input  logic              freq_change_i,
  input  logic              status_wr_i,
  input  logic              status_wdata_i,
  output logic              timeout_status_o,
  output logic              lock_o,
  output logic [1:0]        freq_src_o,
  output logic              chg_ok_o,
  output logic              rst_n_o,
  output logic              rst_oe_o
);
  import fwd_pkg::*;

  logic  accept, start, run, tick, expire, pulse_trig, pulse_act;
  logic  lock_q, sel_q, status_q, chg_ok_q;
  src_e  src;

  assign accept     = freq_change_i && !lock_q;
  assign start      = accept && wd_en_i;
  assign pulse_trig = (expire && rst_on_wd_i) || (accept && rst_on_fchg_i);

  fwd_tick #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (start),
    .long_i    (long_unit_i),
    .tick_o    (tick)
  );

  fwd_count #(.CODE_W(CODE_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wd_en_i),
    .start_i  (start),
    .code_i   (timeout_code_i),
    .tick_i   (tick),
    .run_o    (run),
    .expire_o (expire)
  );

  fwd_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (pulse_trig),
    .active_o (pulse_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      sel_q    <= 1'b0;
      status_q <= 1'b0;
      chg_ok_q <= 1'b0;
    end else begin
      chg_ok_q <= accept;
      if (!wd_en_i)    lock_q <= 1'b0;
      else if (expire) lock_q <= 1'b1;
      if (expire) sel_q <= rcv_src_i;
      // a set on expiry wins over a clear in the same cycle
      if (expire)                             status_q <= 1'b1;
      else if (status_wr_i && status_wdata_i) status_q <= 1'b0;
    end
  end

  always_comb begin
    if (!lock_q)    src = SRC_NORMAL;
    else if (sel_q) src = SRC_PROG;
    else            src = SRC_STRAP;
  end

  assign timeout_status_o = status_q;
  assign lock_o           = lock_q;
  assign freq_src_o       = src;
  assign chg_ok_o         = chg_ok_q;
  assign rst_oe_o         = pulse_act;
  assign rst_n_o          = !pulse_act;
endmodule

// File: rtl/freq_watchdog_chk.sv
module freq_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wd_en_i,
  input logic rst_on_wd_i,
  input logic rst_on_fchg_i,
  input logic status_wr_i,
  input logic status_wdata_i,
  input logic timeout_status_o,
  input logic lock_o,
  input logic chg_ok_o,
  input logic rst_oe_o
);
  // R7
  status_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_status_o) |-> lock_o);

  // R9
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !lock_o);

  // R8
  no_ack_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_ok_o |-> $past(!lock_o));

  // R10
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_oe_o) |-> $past(rst_on_wd_i || rst_on_fchg_i));

  // R6
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(timeout_status_o && !(status_wr_i && status_wdata_i)) |-> timeout_status_o);
endmodule

bind freq_watchdog freq_watchdog_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .wd_en_i          (wd_en_i),
  .rst_on_wd_i      (rst_on_wd_i),
  .rst_on_fchg_i    (rst_on_fchg_i),
  .status_wr_i      (status_wr_i),
  .status_wdata_i   (status_wdata_i),
  .timeout_status_o (timeout_status_o),
  .lock_o           (lock_o),
  .chg_ok_o         (chg_ok_o),
  .rst_oe_o         (rst_oe_o)
);

// File: tb/sim_freq_watchdog.sv
`timescale 1ns/1ps
module sim_freq_watchdog;
  localparam int ST = 8;
  localparam int LT = 32;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wd_en = 0, long_unit = 0, rst_on_wd = 0, rst_on_fchg = 0, rcv_src = 0;
  logic freq_change = 0, status_wr = 0, status_wdata = 0;
  logic [4:0] code = 5'd3;
  logic status, lock, chg_ok, rst_n, rst_oe;
  logic [1:0] fsrc;

  always #2.5 clk = ~clk;

  freq_watchdog #(.SHORT_TICKS(ST), .LONG_TICKS(LT), .RST_LEN(RL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wd_en_i(wd_en), .timeout_code_i(code),
    .long_unit_i(long_unit), .rst_on_wd_i(rst_on_wd), .rst_on_fchg_i(rst_on_fchg),
    .rcv_src_i(rcv_src), .freq_change_i(freq_change), .status_wr_i(status_wr),
    .status_wdata_i(status_wdata), .timeout_status_o(status), .lock_o(lock),
    .freq_src_o(fsrc), .chg_ok_o(chg_ok), .rst_n_o(rst_n), .rst_oe_o(rst_oe)
  );

  typedef struct { int kind; int cyc; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  logic prev_status = 0, prev_oe = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_evt(input int kind, input int c, input string tag);
    item_t it;
    it.kind = kind; it.cyc = c; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: kinds 0=ack, 1=status rise, 2=reset rise
  task automatic observe(input int kind);
    item_t it;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL unexpected event kind=%0d at cycle %0d expected=none", kind, cyc);
    end else begin
      it = sb.pop_front();
      if (it.kind != kind || it.cyc != cyc) begin
        errors++;
        $display("FAIL %s actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                 it.tag, kind, cyc, it.kind, it.cyc);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (chg_ok) observe(0);
      if (status && !prev_status) observe(1);
      if (rst_oe && !prev_oe) observe(2);
    end
    prev_status <= status;
    prev_oe <= rst_oe;
  end

  task automatic fire(input bit exp_ok, input bit exp_rst, input string tag, output int e);
    @(negedge clk);
    freq_change = 1'b1;
    e = cyc + 1;
    if (exp_ok) expect_evt(0, e, tag);
    if (exp_rst) expect_evt(2, e, tag);
    @(negedge clk);
    freq_change = 1'b0;
  endtask

  task automatic at_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_status(input logic d);
    @(negedge clk);
    status_wr = 1'b1; status_wdata = d;
    @(negedge clk);
    status_wr = 1'b0; status_wdata = 1'b0;
  endtask

  task automatic finish_run();
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 pending events actual=%0d expected=0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, e2;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 lock", lock, 0);
    chk("R1 src", fsrc, 0);
    chk("R1 rst_n", rst_n, 1);
    chk("R1 rst_oe", rst_oe, 0);
    chk("R1 ack", chg_ok, 0);

    // R2 short unit, code 3; R10 no pulse with rst_on_wd=0; R12 ack
    wd_en = 1; code = 5'd3; long_unit = 0; rcv_src = 0;
    wait_n(5);
    fire(1, 0, "R12 ack", e);
    expect_evt(1, e + 3*ST, "R2 short expiry");
    wait_n(3*ST + 4);
    chk("R7 lock after expiry", lock, 1);
    chk("R7 strap source", fsrc, 2'b01);

    // R8 refused while locked, even with reset-on-change set
    rst_on_fchg = 1;
    fire(0, 0, "R8 refused", e);
    wait_n(3*ST + 6);
    chk("R8 still locked", lock, 1);
    rst_on_fchg = 0;

    // R6 write 0 ignored, write 1 clears
    write_status(1'b0);
    chk("R6 write0 ignored", status, 1);
    write_status(1'b1);
    chk("R6 write1 clears", status, 0);

    // R9 unlock
    @(negedge clk); wd_en = 0;
    wait_n(2);
    chk("R9 unlock", lock, 0);
    chk("R7 normal source", fsrc, 2'b00);

    // R2 long unit, R10 pulse on expiry, R7 programmed source
    wd_en = 1; long_unit = 1; code = 5'd2; rcv_src = 1; rst_on_wd = 1;
    fire(1, 0, "R12 ack long", e);
    expect_evt(1, e + 2*LT, "R2 long expiry");
    expect_evt(2, e + 2*LT, "R10 reset on expiry");
    at_cycle(e + 2*LT);
    chk("R10 rst_n low", rst_n, 0);
    at_cycle(e + 2*LT + RL - 1);
    chk("R10 pulse held", rst_oe, 1);
    at_cycle(e + 2*LT + RL);
    chk("R10 pulse length", rst_oe, 0);
    chk("R7 prog source", fsrc, 2'b10);
    rst_on_wd = 0; rcv_src = 0;
    write_status(1'b1);
    @(negedge clk); wd_en = 0;
    @(negedge clk); wd_en = 1;

    // R5 restart mid-count
    long_unit = 0; code = 5'd4;
    fire(1, 0, "R12 ack first", e);
    wait_n(18);
    fire(1, 0, "R5 ack second", e2);
    expect_evt(1, e2 + 4*ST, "R5 restart expiry");
    wait_n(4*ST + 4);
    chk("R5 lock", lock, 1);
    write_status(1'b1);
    @(negedge clk); wd_en = 0;
    @(negedge clk); wd_en = 1;

    // R4 disarm mid-count, no expiry follows
    fire(1, 0, "R4 ack", e);
    wait_n(10);
    @(negedge clk); wd_en = 0;
    @(negedge clk); wd_en = 1;
    wait_n(4*ST + 20);
    chk("R4 no status", status, 0);
    chk("R4 no lock", lock, 0);

    // R3 code 0 means 32 units
    code = 5'd0;
    fire(1, 0, "R3 ack", e);
    expect_evt(1, e + 32*ST, "R3 code zero expiry");
    at_cycle(e + 32*ST - 1);
    chk("R3 not yet", status, 0);
    at_cycle(e + 32*ST + 2);
    chk("R3 expired", status, 1);
    write_status(1'b1);

    // R11 reset on change while disarmed
    @(negedge clk); wd_en = 0; rst_on_fchg = 1;
    wait_n(2);
    fire(1, 1, "R11 reset on change", e);
    at_cycle(e + RL - 1);
    chk("R11 pulse held", rst_oe, 1);
    at_cycle(e + RL);
    chk("R11 pulse end", rst_oe, 0);
    rst_on_fchg = 0;
    wait_n(10);
    finish_run();
  end
endmodule